// File: doc/BRIEF.md
# System Control Register Access Gate

This block decides what happens when software reads or writes one guarded 64-bit control register. The register can be reached through two encodings: a primary name and a second name meant for use from the hypervisor level (the "level-12" name). Given the requester's privilege level (0 to 3), the encoding, the direction and a set of control inputs from the higher levels, the block resolves one outcome. The outcome can be undefined, a trap to level 2, a trap to level 3, an access to the local register, an access to a memory-backed copy, or an access redirected to the level-2 trap control register. The control inputs are: whether level 3 exists, the trap bits of levels 2 and 3, the fine-grained trap controls, a three-bit nested-virtualisation setting, host mode, and two flags that turn level-3 traps into undefined.

The checks follow a fixed order of priority. The first one that applies decides the outcome. The block holds the local register and performs writes to it. The memory copy and the level-2 register live elsewhere, so for those targets the block only reports which one was selected, plus the memory offset. Each accepted request produces its outcome on the response ports one clock later.

Top module: `sysreg_access_gate`

## Requirements
- R1: A request is sampled on a rising clock edge while `req_valid` is high. Its result appears on the response ports from that edge on, and stays until the next edge. Outcome codes: 0 none, 1 undefined, 2 trap to level 2, 3 trap to level 3, 4 local register, 5 memory copy, 6 level-2 trap register.
- R2: Only two encodings are recognised. The primary one is op0=3, op1=0, CRn=1, CRm=0, op2=2. The level-12 one is the same except op1=5. Any other encoding, or `req_valid` low, gives outcome 0 and leaves the register unchanged.
- R3: Any request from level 0 is undefined, whichever encoding is used.
- R4: At level 1, primary encoding, the checks apply in this order, and the first that holds wins:
  - undefined when level 3 exists, `cfg_undef_prio` is set and the level-3 trap bit is set;
  - trap to level 2 when level 2 is enabled and its trap bit is set;
  - the fine-grained trap to level 2;
  - the level-3 trap;
  - memory copy when the nested setting is 3'b111;
  - otherwise the local register.
- R5: The fine-grained trap applies only when all of these hold: the feature is present, level 2 is enabled, and either level 3 is absent or the level-3 fine-grained enable is set. It uses the read bit for reads and the write bit for writes.
- R6: A level-3 trap that applies (level 3 exists and its trap bit is set) becomes undefined instead of a trap to level 3 when `cfg_undef_l3` is set.
- R7: At level 2, primary encoding, the early undefined check and the level-3 trap of R4 and R6 come first. Next, host mode selects the level-2 trap register (code 6). Otherwise the local register is accessed.
- R8: At level 3, the primary encoding always gives the local register.
- R9: At level 1, level-12 encoding:
  - a nested setting of 3'b101 gives the memory copy;
  - any other setting with bit 0 set traps to level 2;
  - all other settings are undefined.
- R10: At levels 2 and 3, the level-12 encoding is undefined unless host mode is set. With host mode set, level 3 gets the local register. Level 2 first applies the level-3 checks of R4 and R6, and then gets the local register.
- R11: The local register resets to zero and is always visible on `ctl_value`. It takes `req_wdata` only on a write whose outcome is the local register. Every other request leaves it unchanged.
- R12: `rsp_class` is 0x18 for outcomes 2 and 3 and 0 otherwise. `rsp_mem_ofs` is 0x100 for outcome 5 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_level | input | 2 | Privilege level of the requester |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 (0 primary, 5 level-12) |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Write data |
| cfg_has_l3 | input | 1 | Level 3 implemented |
| cfg_l2_en | input | 1 | Level 2 enabled in the current security state |
| cfg_l3_trap | input | 1 | Level-3 access trap bit |
| cfg_l2_trap | input | 1 | Level-2 access trap bit |
| cfg_fg_present | input | 1 | Fine-grained trap feature present |
| cfg_fg_l3_en | input | 1 | Level-3 enable for fine-grained traps |
| cfg_fg_rd | input | 1 | Fine-grained trap bit for reads |
| cfg_fg_wr | input | 1 | Fine-grained trap bit for writes |
| cfg_nest | input | 3 | Nested-virtualisation setting |
| cfg_host | input | 1 | Level 2 runs in host mode |
| cfg_undef_prio | input | 1 | Level-3 trap takes undefined priority |
| cfg_undef_l3 | input | 1 | Level-3 trap reported as undefined |
| rsp_outcome | output | 3 | Resolved outcome code |
| rsp_class | output | 6 | Exception class for trap outcomes |
| rsp_mem_ofs | output | 12 | Memory offset for the memory-copy outcome |
| ctl_value | output | 64 | Current contents of the local register |

## Verification
The assertions check properties on every cycle:
- level-0 requests are undefined;
- unrecognised or absent requests yield no outcome;
- level 3 through the primary encoding is always a local access;
- the level-12 encoding above level 1 without host mode is undefined;
- the register changes only on a local outcome;
- class and offset agree with the outcome.

The priority order among the checks at levels 1 and 2 cannot be seen by the assertions. Neither can the fine-grained direction select, the nested-setting redirection, or the value actually written. Only the bench shows these. It runs an ordered reference model over pseudo-random control settings and every level, encoding and direction, and adds directed cases for each rung of the chain.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [2:0] {
        OC_NONE     = 3'd0,
        OC_UNDEF    = 3'd1,
        OC_TRAP2    = 3'd2,
        OC_TRAP3    = 3'd3,
        OC_LOCAL    = 3'd4,
        OC_MEMCOPY  = 3'd5,
        OC_TRAP2REG = 3'd6
    } outcome_e;

    typedef enum logic {
        AL_PRIMARY = 1'b0,
        AL_L12     = 1'b1
    } alias_e;

    typedef struct packed {
        logic       has_l3;
        logic       l2_en;
        logic       l3_trap;
        logic       l2_trap;
        logic       fg_present;
        logic       fg_l3_en;
        logic       fg_rd;
        logic       fg_wr;
        logic       host;
        logic       undef_prio;
        logic       undef_l3;
        logic [2:0] nest;
    } ctrl_t;

    localparam logic [5:0] TRAP_CLASS = 6'h18;
    localparam logic [2:0] NEST_MEM_PRIMARY = 3'b111;
    localparam logic [2:0] NEST_MEM_L12     = 3'b101;

endpackage

// File: rtl/sag_decode.sv
module sag_decode
    import sag_pkg::*;
#(
    parameter logic [1:0] OP0     = 2'd3,
    parameter logic [2:0] OP1_PRI = 3'd0,
    parameter logic [2:0] OP1_ALT = 3'd5,
    parameter logic [3:0] CRN     = 4'd1,
    parameter logic [3:0] CRM     = 4'd0,
    parameter logic [2:0] OP2     = 3'd2
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit,
    output alias_e     alias_sel
);
    logic common_ok;

    // Both names share every field except op1.
    always_comb begin
        common_ok = (op0 == OP0) && (crn == CRN) && (crm == CRM) && (op2 == OP2);
        hit       = common_ok && ((op1 == OP1_PRI) || (op1 == OP1_ALT));
        alias_sel = (op1 == OP1_ALT) ? AL_L12 : AL_PRIMARY;
    end
endmodule

// File: rtl/sag_l3_gate.sv
module sag_l3_gate
    import sag_pkg::*;
(
    input  logic     has_l3,
    input  logic     l3_trap,
    input  logic     undef_prio,
    input  logic     undef_l3,
    output logic     early_undef,
    output logic     late_fire,
    output outcome_e late_outcome
);
    // Early rung: undefined ahead of every level-2 check.
    // Late rung: trap to level 3, or undefined when the flag asks for it.
    always_comb begin
        early_undef  = has_l3 && undef_prio && l3_trap;
        late_fire    = has_l3 && l3_trap;
        late_outcome = undef_l3 ? OC_UNDEF : OC_TRAP3;
    end
endmodule

// File: rtl/sag_resolver.sv
module sag_resolver
    import sag_pkg::*;
(
    input  logic [1:0] level,
    input  alias_e     alias_sel,
    input  logic       is_write,
    input  ctrl_t      ctrl,
    output outcome_e   verdict
);
    logic     early_undef;
    logic     late_fire;
    outcome_e late_outcome;
    logic     fg_hit;

    sag_l3_gate u_l3_gate (
        .has_l3       (ctrl.has_l3),
        .l3_trap      (ctrl.l3_trap),
        .undef_prio   (ctrl.undef_prio),
        .undef_l3     (ctrl.undef_l3),
        .early_undef  (early_undef),
        .late_fire    (late_fire),
        .late_outcome (late_outcome)
    );

    always_comb begin
        fg_hit = ctrl.l2_en && ctrl.fg_present &&
                 (!ctrl.has_l3 || ctrl.fg_l3_en) &&
                 (is_write ? ctrl.fg_wr : ctrl.fg_rd);
        verdict = OC_UNDEF;
        if (alias_sel == AL_PRIMARY) begin
            case (level)
                2'd0: verdict = OC_UNDEF;
                2'd1: begin
                    if (early_undef)                      verdict = OC_UNDEF;
                    else if (ctrl.l2_en && ctrl.l2_trap)  verdict = OC_TRAP2;
                    else if (fg_hit)                      verdict = OC_TRAP2;
                    else if (late_fire)                   verdict = late_outcome;
                    else if (ctrl.nest == NEST_MEM_PRIMARY) verdict = OC_MEMCOPY;
                    else                                  verdict = OC_LOCAL;
                end
                2'd2: begin
                    if (early_undef)    verdict = OC_UNDEF;
                    else if (late_fire) verdict = late_outcome;
                    else if (ctrl.host) verdict = OC_TRAP2REG;
                    else                verdict = OC_LOCAL;
                end
                default: verdict = OC_LOCAL;
            endcase
        end else begin
            case (level)
                2'd0: verdict = OC_UNDEF;
                2'd1: begin
                    if (ctrl.nest == NEST_MEM_L12) verdict = OC_MEMCOPY;
                    else if (ctrl.nest[0])         verdict = OC_TRAP2;
                    else                           verdict = OC_UNDEF;
                end
                2'd2: begin
                    if (!ctrl.host)     verdict = OC_UNDEF;
                    else if (early_undef) verdict = OC_UNDEF;
                    else if (late_fire) verdict = late_outcome;
                    else                verdict = OC_LOCAL;
                end
                default: verdict = ctrl.host ? OC_LOCAL : OC_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/sysreg_access_gate.sv
module sysreg_access_gate
    import sag_pkg::*;
#(
    parameter int              DATA_W    = 64,
    parameter int              OFS_W     = 12,
    parameter logic [OFS_W-1:0] MEM_OFS  = 12'h100,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_level,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_has_l3,
    input  logic              cfg_l2_en,
    input  logic              cfg_l3_trap,
    input  logic              cfg_l2_trap,
    input  logic              cfg_fg_present,
    input  logic              cfg_fg_l3_en,
    input  logic              cfg_fg_rd,
    input  logic              cfg_fg_wr,
    input  logic [2:0]        cfg_nest,
    input  logic              cfg_host,
    input  logic              cfg_undef_prio,
    input  logic              cfg_undef_l3,
    output logic [2:0]        rsp_outcome,
    output logic [5:0]        rsp_class,
    output logic [OFS_W-1:0]  rsp_mem_ofs,
    output logic [DATA_W-1:0] ctl_value
);
    typedef struct packed {
        outcome_e          outcome;
        logic [5:0]        cls;
        logic [OFS_W-1:0]  mofs;
        logic [DATA_W-1:0] value;
    } state_t;

    state_t   st_d, st_q;
    ctrl_t    ctrl;
    logic     hit;
    alias_e   alias_sel;
    outcome_e verdict;

    always_comb begin
        ctrl.has_l3     = cfg_has_l3;
        ctrl.l2_en      = cfg_l2_en;
        ctrl.l3_trap    = cfg_l3_trap;
        ctrl.l2_trap    = cfg_l2_trap;
        ctrl.fg_present = cfg_fg_present;
        ctrl.fg_l3_en   = cfg_fg_l3_en;
        ctrl.fg_rd      = cfg_fg_rd;
        ctrl.fg_wr      = cfg_fg_wr;
        ctrl.host       = cfg_host;
        ctrl.undef_prio = cfg_undef_prio;
        ctrl.undef_l3   = cfg_undef_l3;
        ctrl.nest       = cfg_nest;
    end

    sag_decode u_decode (
        .op0       (req_op0),
        .op1       (req_op1),
        .crn       (req_crn),
        .crm       (req_crm),
        .op2       (req_op2),
        .hit       (hit),
        .alias_sel (alias_sel)
    );

    sag_resolver u_resolver (
        .level     (req_level),
        .alias_sel (alias_sel),
        .is_write  (req_write),
        .ctrl      (ctrl),
        .verdict   (verdict)
    );

    always_comb begin
        st_d         = st_q;
        st_d.outcome = OC_NONE;
        st_d.cls     = '0;
        st_d.mofs    = '0;
        if (req_valid && hit) begin
            st_d.outcome = verdict;
            if (verdict == OC_TRAP2 || verdict == OC_TRAP3) st_d.cls  = TRAP_CLASS;
            if (verdict == OC_MEMCOPY)                      st_d.mofs = MEM_OFS;
            if (verdict == OC_LOCAL && req_write)           st_d.value = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.outcome <= OC_NONE;
            st_q.cls     <= '0;
            st_q.mofs    <= '0;
            st_q.value   <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_outcome = st_q.outcome;
    assign rsp_class   = st_q.cls;
    assign rsp_mem_ofs = st_q.mofs;
    assign ctl_value   = st_q.value;

    p_idle_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !hit) |=> (st_q.outcome == OC_NONE));

    p_level0_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_level == 2'd0) |=> (st_q.outcome == OC_UNDEF));

    p_top_primary_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_level == 2'd3 && alias_sel == AL_PRIMARY)
        |=> (st_q.outcome == OC_LOCAL));

    p_alias_needs_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && req_level[1] && alias_sel == AL_L12 && !cfg_host)
        |=> (st_q.outcome == OC_UNDEF));

    p_write_only_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.value) |-> (st_q.outcome == OC_LOCAL));

    p_class_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cls == TRAP_CLASS) == (st_q.outcome == OC_TRAP2 || st_q.outcome == OC_TRAP3)));

    p_offset_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mofs != '0) == (st_q.outcome == OC_MEMCOPY)));
endmodule

// File: tb/sysreg_access_gate_bench.sv
module sysreg_access_gate_bench;
    localparam logic [2:0] E_NONE = 3'd0, E_UNDEF = 3'd1, E_TRAP2 = 3'd2, E_TRAP3 = 3'd3,
                           E_LOCAL = 3'd4, E_MEM = 3'd5, E_T2REG = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_level = '0;
    logic [1:0]  req_op0 = '0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        cfg_has_l3 = 0, cfg_l2_en = 0, cfg_l3_trap = 0, cfg_l2_trap = 0;
    logic        cfg_fg_present = 0, cfg_fg_l3_en = 0, cfg_fg_rd = 0, cfg_fg_wr = 0;
    logic [2:0]  cfg_nest = '0;
    logic        cfg_host = 0, cfg_undef_prio = 0, cfg_undef_l3 = 0;
    logic [2:0]  rsp_outcome;
    logic [5:0]  rsp_class;
    logic [11:0] rsp_mem_ofs;
    logic [63:0] ctl_value;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] mdl_value = '0;
    logic [31:0] rng = 32'h1234_5679;

    always #5 clk = ~clk;

    sysreg_access_gate u_sysreg_access_gate (
        .clk, .rst_n, .req_valid, .req_level, .req_op0, .req_op1, .req_crn, .req_crm,
        .req_op2, .req_write, .req_wdata, .cfg_has_l3, .cfg_l2_en, .cfg_l3_trap,
        .cfg_l2_trap, .cfg_fg_present, .cfg_fg_l3_en, .cfg_fg_rd, .cfg_fg_wr, .cfg_nest,
        .cfg_host, .cfg_undef_prio, .cfg_undef_l3, .rsp_outcome, .rsp_class,
        .rsp_mem_ofs, .ctl_value
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Control vector bits: 0 has_l3, 1 l2_en, 2 l3_trap, 3 l2_trap, 4 fg_present,
    // 5 fg_l3_en, 6 fg_rd, 7 fg_wr, 8 host, 9 undef_prio, 10 undef_l3, 13:11 nest.
    task automatic set_ctrl(input logic [13:0] c);
        cfg_has_l3 = c[0];  cfg_l2_en = c[1];   cfg_l3_trap = c[2];  cfg_l2_trap = c[3];
        cfg_fg_present = c[4]; cfg_fg_l3_en = c[5]; cfg_fg_rd = c[6]; cfg_fg_wr = c[7];
        cfg_host = c[8]; cfg_undef_prio = c[9]; cfg_undef_l3 = c[10]; cfg_nest = c[13:11];
    endtask

    // Ordered reference model written from the requirements.
    function automatic logic [2:0] model(input logic [1:0] lv, input logic alt,
                                         input logic wr, input logic [13:0] c);
        logic early, late, fg;
        logic [2:0] late_oc;
        early   = c[0] & c[9] & c[2];
        late    = c[0] & c[2];
        late_oc = c[10] ? E_UNDEF : E_TRAP3;
        fg      = c[1] & c[4] & (~c[0] | c[5]) & (wr ? c[7] : c[6]);
        if (lv == 2'd0) return E_UNDEF;
        if (!alt) begin
            if (lv == 2'd3) return E_LOCAL;
            if (early) return E_UNDEF;
            if (lv == 2'd1) begin
                if (c[1] & c[3]) return E_TRAP2;
                if (fg) return E_TRAP2;
                if (late) return late_oc;
                if (c[13:11] == 3'b111) return E_MEM;
                return E_LOCAL;
            end
            if (late) return late_oc;
            return c[8] ? E_T2REG : E_LOCAL;
        end
        if (lv == 2'd1) begin
            if (c[13:11] == 3'b101) return E_MEM;
            if (c[11]) return E_TRAP2;
            return E_UNDEF;
        end
        if (!c[8]) return E_UNDEF;
        if (lv == 2'd3) return E_LOCAL;
        if (early) return E_UNDEF;
        if (late) return late_oc;
        return E_LOCAL;
    endfunction

    // Drive one request at a falling edge, sample after the next rising edge.
    task automatic do_req(input string req, input logic [1:0] lv, input logic alt,
                          input logic wr, input logic [63:0] wd, input logic [13:0] c);
        logic [2:0] exp;
        set_ctrl(c);
        req_valid = 1'b1; req_level = lv; req_op0 = 2'd3; req_op1 = alt ? 3'd5 : 3'd0;
        req_crn = 4'd1; req_crm = 4'd0; req_op2 = 3'd2; req_write = wr; req_wdata = wd;
        exp = model(lv, alt, wr, c);
        if (exp == E_LOCAL && wr) mdl_value = wd;
        @(posedge clk);
        @(negedge clk);
        chk({req, " outcome"}, {61'd0, rsp_outcome}, {61'd0, exp});
        chk({req, " class R12"}, {58'd0, rsp_class},
            (exp == E_TRAP2 || exp == E_TRAP3) ? 64'h18 : 64'h0);
        chk({req, " offset R12"}, {52'd0, rsp_mem_ofs}, (exp == E_MEM) ? 64'h100 : 64'h0);
        chk({req, " value R11"}, ctl_value, mdl_value);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset outcome", {61'd0, rsp_outcome}, 64'd0);
        chk("R11 reset value", ctl_value, 64'd0);
        chk("R12 reset class", {58'd0, rsp_class}, 64'd0);
    endtask

    task automatic t_decode();
        // R2: each field off by one, and valid low, give no outcome and no write.
        for (int k = 0; k < 6; k++) begin
            set_ctrl(14'd0);
            req_valid = (k != 5); req_level = 2'd3; req_write = 1'b1;
            req_wdata = 64'hDEAD_0000_0000_0000 + 64'(k);
            req_op0 = (k == 0) ? 2'd2 : 2'd3;
            req_op1 = (k == 1) ? 3'd4 : 3'd0;
            req_crn = (k == 2) ? 4'd2 : 4'd1;
            req_crm = (k == 3) ? 4'd1 : 4'd0;
            req_op2 = (k == 4) ? 3'd3 : 3'd2;
            @(posedge clk);
            @(negedge clk);
            chk("R2 unmatched outcome", {61'd0, rsp_outcome}, 64'd0);
            chk("R2 unmatched no write", ctl_value, mdl_value);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_directed();
        do_req("R8 level3 write", 2'd3, 1'b0, 1'b1, 64'hA5A5_0001_0002_0003, 14'h3FFF);
        do_req("R3 level0 write", 2'd0, 1'b0, 1'b1, 64'h1, 14'd0);
        do_req("R3 level0 alias", 2'd0, 1'b1, 1'b0, 64'h0, 14'h0100);
        // R4: level-2 trap bit outranks fine-grained and level-3 trap.
        do_req("R4 l2 trap first", 2'd1, 1'b0, 1'b1, 64'h2, 14'b000_0_0_0_1_1_1_1_1_1_1_1);
        // R4: early undefined outranks level-2 trap.
        do_req("R4 early undef", 2'd1, 1'b0, 1'b0, 64'h0, 14'b000_0_1_0_0_0_0_0_1_1_1_1);
        // R5: fine-grained ignored when level 3 present without its enable -> level-3 trap.
        do_req("R5 fg gated", 2'd1, 1'b0, 1'b0, 64'h0, 14'b000_0_0_0_0_1_0_1_0_1_1_1);
        // R5: write uses write bit only -> falls to local.
        do_req("R5 fg dir", 2'd1, 1'b0, 1'b1, 64'h5555, 14'b000_0_0_0_0_1_0_1_0_0_1_0);
        // R6: undef flag turns level-3 trap into undefined.
        do_req("R6 late undef", 2'd1, 1'b0, 1'b0, 64'h0, 14'b000_1_0_0_0_0_0_0_0_1_0_1);
        do_req("R4 nest mem", 2'd1, 1'b0, 1'b1, 64'h7, 14'b111_0_0_0_0_0_0_0_0_0_1_0);
        do_req("R7 host remap", 2'd2, 1'b0, 1'b1, 64'h9, 14'b000_0_0_1_0_0_0_0_0_0_0_0);
        do_req("R7 l3 trap", 2'd2, 1'b0, 1'b1, 64'h9, 14'b000_0_0_1_0_0_0_0_0_1_0_1);
        do_req("R9 alias mem", 2'd1, 1'b1, 1'b0, 64'h0, 14'b101_0_0_0_0_0_0_0_0_0_0_0);
        do_req("R9 alias trap", 2'd1, 1'b1, 1'b0, 64'h0, 14'b011_0_0_0_0_0_0_0_0_0_0_0);
        do_req("R9 alias undef", 2'd1, 1'b1, 1'b0, 64'h0, 14'b110_0_0_0_0_0_0_0_0_0_0_0);
        do_req("R10 alias nohost", 2'd3, 1'b1, 1'b1, 64'hB, 14'd0);
        do_req("R10 alias host l2", 2'd2, 1'b1, 1'b1, 64'hC0FFEE, 14'b000_0_0_1_0_0_0_0_0_0_0_0);
    endtask

    task automatic t_sweep(input int n);
        for (int i = 0; i < n; i++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            for (int j = 0; j < 16; j++) begin
                do_req("R4 R5 R6 R7 R9 R10 sweep", j[3:2], j[1], j[0],
                       {rng, rng ^ 32'h0F0F_3C3C}, rng[13:0]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_directed();
        t_sweep(1500);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule